// File: doc/BRIEF.md
# Hill-Climbing Lock Key Search Engine

This block searches for the unlock key of a key-locked combinational circuit. After a start pulse it drives a candidate key and a stored set of test patterns into the circuit. It compares every response with a stored golden response. The cost of a candidate is the number of differing output bits, summed over the whole pattern set. The engine then runs a greedy search. It flips one key bit at a time, keeps a flip that does not raise the cost, and undoes a flip that does.

A 16-bit maximal-length LFSR supplies the randomness. It gives each fresh candidate its initial bits and fixes the order in which the bits of a pass are visited. The LFSR is seeded at start, so a run can be repeated exactly. A zero-cost candidate is not trusted by itself, because different keys can give the same test response. It goes to an external correctness check. A rejection there counts as a false match, and the search restarts from a new random key. A pass that visits every bit without reaching zero cost also restarts. When the budget of evaluated key combinations is used up, the search ends with the found flag low.

Top module: `key_search_engine`

## Requirements
- R1: After reset, `done`, `found` and `verify_req` are 0, and `result_key` and `pat_idx` are 0.
- R2: An evaluation drives `pat_idx` through 0 to NPAT-1 on consecutive cycles, with `pat_data` equal to ROM entry `pat_idx`. Entry i occupies bits [i*PAT_W +: PAT_W] of PAT_ROM. `dut_key` is held constant across the sweep.
- R3: The cost of a candidate is the number of bits in which `dut_rsp` differs from EXP_ROM entry `pat_idx`, summed over all NPAT patterns. The accumulator saturates at NPAT*RSP_W. `dut_rsp` is sampled in the same cycle as the pattern it answers.
- R4: A trial flips one key bit and is followed by a full evaluation. The flip is undone only if the previous cost was strictly lower. On a circuit where each wrong key bit adds its own mismatches, the search returns the true key.
- R5: `verify_req` is raised for one cycle only when the current cost is zero. If `verify_ok` is 1 in that cycle, the next cycle gives `done` with `found`=1, and `result_key` holds the checked key.
- R6: If `verify_ok` is 0 during a `verify_req` cycle, the search restarts from a new random key and continues.
- R7: Once MAX_EVALS full evaluations have been made, the engine stops before starting another evaluation and raises `done` with `found`=0.
- R8: `done` is a one-cycle pulse. `found` and `result_key` hold their values until the next `start` and are cleared one cycle after it.
- R9: `seed` is loaded into the LFSR at `start`, and a zero seed is replaced by 1. The same seed therefore gives the same run, and seeds 0 and 1 give identical runs.
- R10: Each pass visits every key bit exactly once, in an LFSR-chosen order. From any initial key, an additive circuit is solved within one base evaluation plus KEY_W trials.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when the engine is idle |
| seed | input | 16 | LFSR seed loaded at start |
| done | output | 1 | One-cycle pulse at the end of a search |
| found | output | 1 | The search ended with a confirmed key |
| result_key | output | KEY_W | Confirmed key, or the last candidate on failure |
| dut_key | output | KEY_W | Candidate key driven into the locked circuit |
| pat_idx | output | $clog2(NPAT) | Index of the pattern being applied |
| pat_data | output | PAT_W | Test pattern driven into the locked circuit |
| dut_rsp | input | RSP_W | Response of the locked circuit |
| verify_req | output | 1 | Asks for a correctness check of `dut_key` |
| verify_ok | input | 1 | Same-cycle answer to `verify_req` |

## Verification
The in-RTL assertions check the following on every cycle:
- `done` lasts a single cycle.
- The result stays stable while the engine is idle.
- A check is requested only at zero cost.
- A confirmed result always follows an accepted check.
- The pattern index steps by one under a constant key.
- The mismatch accumulator never passes its ceiling.
- The evaluation count never passes the budget.
- The LFSR never holds zero.

Only the bench scenarios can show that the greedy keep-or-undo rule and the bit-visit permutation actually converge on the true key within one pass. They also show that false matches lead to restarts with the right number of checks, that budget exhaustion reports failure, and that the seed makes runs repeatable.

// File: rtl/ks_pkg.sv
package ks_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_INIT   = 3'd1,
        S_EVAL   = 3'd2,
        S_TOGGLE = 3'd3,
        S_VERIFY = 3'd4,
        S_DONE   = 3'd5
    } ks_state_e;

    localparam int LFSR_W   = 16;
    localparam logic [LFSR_W-1:0] LFSR_ONE = 16'h0001;
endpackage

// File: rtl/ks_lfsr.sv
module ks_lfsr
    import ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] q
);
    logic [LFSR_W-1:0] state_d, state_q;
    logic              fb;

    always_comb begin
        fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
        state_d = state_q;
        if (load) begin
            state_d = (seed == '0) ? LFSR_ONE : seed;
        end else if (step) begin
            state_d = {state_q[LFSR_W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LFSR_ONE;
        else        state_q <= state_d;
    end

    assign q = state_q;

    // R9
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/ks_rom.sv
module ks_rom #(
    parameter int NPAT  = 16,
    parameter int PAT_W = 8,
    parameter int RSP_W = 8,
    parameter int IDX_W = $clog2(NPAT),
    parameter logic [NPAT*PAT_W-1:0] PAT_ROM = '0,
    parameter logic [NPAT*RSP_W-1:0] EXP_ROM = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [PAT_W-1:0] pat,
    output logic [RSP_W-1:0] exp_rsp
);
    logic [PAT_W-1:0] pat_a [NPAT];
    logic [RSP_W-1:0] exp_a [NPAT];

    for (genvar i = 0; i < NPAT; i++) begin : g_ent
        assign pat_a[i] = PAT_ROM[i*PAT_W +: PAT_W];
        assign exp_a[i] = EXP_ROM[i*RSP_W +: RSP_W];
    end

    assign pat     = pat_a[idx];
    assign exp_rsp = exp_a[idx];
endmodule

// File: rtl/ks_mismatch_acc.sv
module ks_mismatch_acc #(
    parameter int RSP_W = 8,
    parameter int NPAT  = 16,
    localparam int MAX_CNT = NPAT * RSP_W,
    localparam int CNT_W   = $clog2(MAX_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic [RSP_W-1:0] rsp,
    input  logic [RSP_W-1:0] exp_rsp,
    output logic [CNT_W-1:0] sum_now
);
    logic [CNT_W-1:0] acc_d, acc_q;
    logic [CNT_W-1:0] pc;
    logic [CNT_W:0]   wide;
    logic [RSP_W-1:0] diff;

    always_comb begin
        diff = rsp ^ exp_rsp;
        pc   = '0;
        for (int i = 0; i < RSP_W; i++) begin
            pc = pc + CNT_W'(diff[i]);
        end
        wide    = {1'b0, acc_q} + {1'b0, pc};
        sum_now = (wide > (CNT_W+1)'(MAX_CNT)) ? CNT_W'(MAX_CNT) : wide[CNT_W-1:0];
        acc_d   = acc_q;
        if (clear)   acc_d = '0;
        else if (en) acc_d = sum_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3
    acc_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/key_search_engine.sv
module key_search_engine
    import ks_pkg::*;
#(
    parameter int KEY_W     = 8,
    parameter int NPAT      = 16,
    parameter int PAT_W     = 8,
    parameter int RSP_W     = 8,
    parameter int MAX_EVALS = 1000000,
    parameter logic [NPAT*PAT_W-1:0] PAT_ROM = '0,
    parameter logic [NPAT*RSP_W-1:0] EXP_ROM = '0,
    localparam int IDX_W   = $clog2(NPAT),
    localparam int BIT_W   = $clog2(KEY_W),
    localparam int MAX_CNT = NPAT * RSP_W,
    localparam int CNT_W   = $clog2(MAX_CNT + 1),
    localparam int EV_W    = $clog2(MAX_EVALS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       seed,
    output logic              done,
    output logic              found,
    output logic [KEY_W-1:0]  result_key,
    output logic [KEY_W-1:0]  dut_key,
    output logic [IDX_W-1:0]  pat_idx,
    output logic [PAT_W-1:0]  pat_data,
    input  logic [RSP_W-1:0]  dut_rsp,
    output logic              verify_req,
    input  logic              verify_ok
);
    typedef struct packed {
        ks_state_e        state;
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] cost;
        logic [IDX_W-1:0] idx;
        logic [BIT_W:0]   visit;
        logic [BIT_W-1:0] off;
        logic [BIT_W-1:0] stride;
        logic             trial;
        logic [EV_W-1:0]  evals;
        logic             found;
        logic [KEY_W-1:0] result;
    } regs_t;

    regs_t q, d;

    logic [LFSR_W-1:0]  rnd;
    logic               lfsr_load, lfsr_step;
    logic [RSP_W-1:0]   exp_rsp;
    logic [CNT_W-1:0]   sum_now;
    logic               acc_en, acc_clear;
    logic [2*BIT_W-1:0] prod;
    logic [BIT_W-1:0]   bit_sel;
    logic [KEY_W-1:0]   bit_mask;
    logic               last_pat;
    logic               budget_out;
    logic [CNT_W-1:0]   new_cost;

    ks_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lfsr_load),
        .seed  (seed),
        .step  (lfsr_step),
        .q     (rnd)
    );

    ks_rom #(
        .NPAT    (NPAT),
        .PAT_W   (PAT_W),
        .RSP_W   (RSP_W),
        .IDX_W   (IDX_W),
        .PAT_ROM (PAT_ROM),
        .EXP_ROM (EXP_ROM)
    ) u_rom (
        .idx     (q.idx),
        .pat     (pat_data),
        .exp_rsp (exp_rsp)
    );

    ks_mismatch_acc #(
        .RSP_W (RSP_W),
        .NPAT  (NPAT)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (acc_en),
        .clear   (acc_clear),
        .rsp     (dut_rsp),
        .exp_rsp (exp_rsp),
        .sum_now (sum_now)
    );

    always_comb begin
        d          = q;
        prod       = {{BIT_W{1'b0}}, q.visit[BIT_W-1:0]} * {{BIT_W{1'b0}}, q.stride};
        bit_sel    = q.off + prod[BIT_W-1:0];
        bit_mask   = KEY_W'(1) << bit_sel;
        last_pat   = (q.idx == IDX_W'(NPAT - 1));
        budget_out = (q.evals >= EV_W'(MAX_EVALS));
        lfsr_load  = (q.state == S_IDLE) && start;
        lfsr_step  = (q.state != S_IDLE);
        acc_en     = (q.state == S_EVAL);
        acc_clear  = (q.state == S_EVAL) && last_pat;
        new_cost   = sum_now;

        unique case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.found  = 1'b0;
                    d.result = '0;
                    d.evals  = '0;
                    d.state  = S_INIT;
                end
            end
            S_INIT: begin
                if (budget_out) begin
                    d.found  = 1'b0;
                    d.result = q.key;
                    d.state  = S_DONE;
                end else begin
                    d.key   = rnd[KEY_W-1:0];
                    d.trial = 1'b0;
                    d.idx   = '0;
                    d.state = S_EVAL;
                end
            end
            S_EVAL: begin
                d.idx = q.idx + IDX_W'(1);
                if (last_pat) begin
                    d.idx   = '0;
                    d.evals = q.evals + EV_W'(1);
                    if (!q.trial) begin
                        d.cost = sum_now;
                        if (sum_now == '0) begin
                            d.state = S_VERIFY;
                        end else begin
                            d.visit  = '0;
                            d.off    = rnd[BIT_W-1:0];
                            d.stride = rnd[LFSR_W-1 -: BIT_W] | BIT_W'(1);
                            d.state  = S_TOGGLE;
                        end
                    end else begin
                        if (q.cost < sum_now) begin
                            d.key    = q.key ^ bit_mask;
                            new_cost = q.cost;
                        end
                        d.cost = new_cost;
                        if (new_cost == '0) begin
                            d.state = S_VERIFY;
                        end else if (q.visit == (BIT_W+1)'(KEY_W - 1)) begin
                            d.state = S_INIT;
                        end else begin
                            d.visit = q.visit + (BIT_W+1)'(1);
                            d.state = S_TOGGLE;
                        end
                    end
                end
            end
            S_TOGGLE: begin
                if (budget_out) begin
                    d.found  = 1'b0;
                    d.result = q.key;
                    d.state  = S_DONE;
                end else begin
                    d.key   = q.key ^ bit_mask;
                    d.trial = 1'b1;
                    d.idx   = '0;
                    d.state = S_EVAL;
                end
            end
            S_VERIFY: begin
                if (verify_ok) begin
                    d.found  = 1'b1;
                    d.result = q.key;
                    d.state  = S_DONE;
                end else begin
                    d.state = S_INIT;
                end
            end
            S_DONE: begin
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done       = (q.state == S_DONE);
    assign verify_req = (q.state == S_VERIFY);
    assign found      = q.found;
    assign result_key = q.result;
    assign dut_key    = q.key;
    assign pat_idx    = q.idx;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> found);
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && !start) |=> $stable(result_key));
    // R5
    verify_zero_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req |-> (q.cost == '0));
    // R5
    found_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> $past(verify_req && verify_ok));
    // R2
    key_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_EVAL && !last_pat) |=> $stable(dut_key));
    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_EVAL && !last_pat) |=> (pat_idx == $past(pat_idx) + IDX_W'(1)));
    // R7
    budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.evals <= EV_W'(MAX_EVALS));
endmodule

// File: tb/key_search_engine_bench.sv
`timescale 1ns/1ps
module key_search_engine_bench;
    localparam int KEY_W     = 8;
    localparam int NPAT      = 16;
    localparam int PAT_W     = 8;
    localparam int RSP_W     = 8;
    localparam int MAX_EVALS = 40;
    localparam int IDX_W     = $clog2(NPAT);
    localparam logic [KEY_W-1:0] TRUE_KEY = 8'hB6;

    function automatic logic [PAT_W-1:0] pat_f(input int i);
        return PAT_W'((i * 29 + 7) ^ (i << 4));
    endfunction

    // locked model: each key bit sits on its own XOR/XNOR gate
    function automatic logic [RSP_W-1:0] circ(input logic [PAT_W-1:0] p, input logic [KEY_W-1:0] k);
        logic [7:0] n;
        logic [7:0] o;
        n = p ^ k ^ TRUE_KEY;
        for (int j = 0; j < 8; j++) begin
            o[j] = n[j] ^ (p[(j + 1) % 8] & p[(j + 3) % 8]);
        end
        return o;
    endfunction

    function automatic logic [NPAT*PAT_W-1:0] build_pat();
        logic [NPAT*PAT_W-1:0] r;
        for (int i = 0; i < NPAT; i++) r[i*PAT_W +: PAT_W] = pat_f(i);
        return r;
    endfunction

    function automatic logic [NPAT*RSP_W-1:0] build_exp();
        logic [NPAT*RSP_W-1:0] r;
        for (int i = 0; i < NPAT; i++) r[i*RSP_W +: RSP_W] = circ(pat_f(i), TRUE_KEY);
        return r;
    endfunction

    localparam logic [NPAT*PAT_W-1:0] PAT_TAB = build_pat();
    localparam logic [NPAT*RSP_W-1:0] EXP_TAB = build_exp();

    // rows: seed, oracle rejections, expected found
    localparam int NROWS = 6;
    localparam logic [24:0] ROWS [NROWS] = '{
        {16'hACE1, 8'd0, 1'b1},
        {16'h0001, 8'd0, 1'b1},
        {16'h0000, 8'd0, 1'b1},
        {16'h5A3C, 8'd0, 1'b1},
        {16'h0BAD, 8'd1, 1'b1},
        {16'hFFFF, 8'd2, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       seed_i = '0;
    logic              done, found, verify_req, verify_ok;
    logic [KEY_W-1:0]  result_key, dut_key;
    logic [IDX_W-1:0]  pat_idx;
    logic [PAT_W-1:0]  pat_data;
    logic [RSP_W-1:0]  dut_rsp;
    logic [7:0]        reject_left = '0;

    int checks = 0;
    int errors = 0;
    int pat_bad = 0;
    int pat_seen = 0;

    always #4 clk = ~clk;

    assign dut_rsp   = circ(pat_data, dut_key);
    assign verify_ok = verify_req && (dut_key == TRUE_KEY) && (reject_left == 0);

    key_search_engine #(
        .KEY_W     (KEY_W),
        .NPAT      (NPAT),
        .PAT_W     (PAT_W),
        .RSP_W     (RSP_W),
        .MAX_EVALS (MAX_EVALS),
        .PAT_ROM   (PAT_TAB),
        .EXP_ROM   (EXP_TAB)
    ) u_key_search_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .seed       (seed_i),
        .done       (done),
        .found      (found),
        .result_key (result_key),
        .dut_key    (dut_key),
        .pat_idx    (pat_idx),
        .pat_data   (pat_data),
        .dut_rsp    (dut_rsp),
        .verify_req (verify_req),
        .verify_ok  (verify_ok)
    );

    // R2: pattern bus always matches the table entry at the index
    always @(negedge clk) begin
        if (rst_n) begin
            pat_seen <= pat_seen + 1;
            if (pat_data != PAT_TAB[pat_idx*PAT_W +: PAT_W]) pat_bad <= pat_bad + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] sd, input logic [7:0] rej,
                       output int cyc, output int nver, output bit fnd,
                       output logic [KEY_W-1:0] key);
        bit pend;
        @(negedge clk);
        seed_i = sd;
        reject_left = rej;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(found == 1'b0 && result_key == '0, "R8", "cleared after start",
              {found, result_key}, 0);
        cyc = 1;
        nver = 0;
        pend = 1'b0;
        while (!done && cyc < 5000) begin
            if (verify_req) begin
                nver++;
                pend = (dut_key == TRUE_KEY) && (reject_left != 0);
            end
            @(negedge clk);
            cyc++;
            if (pend) begin
                reject_left = reject_left - 8'd1;
                pend = 1'b0;
            end
        end
        check(done == 1'b1, "R7", "search terminates", done, 1);
        fnd = found;
        key = result_key;
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(found == fnd && result_key == key, "R8", "result held",
              {found, result_key}, {fnd, key});
    endtask

    initial begin
        #(200000 * 8);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        int cyc_tab [NROWS];
        int cyc, nver;
        bit fnd;
        logic [KEY_W-1:0] key;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(done == 0 && found == 0 && verify_req == 0, "R1", "flags at reset",
              {done, found, verify_req}, 0);
        check(result_key == 0 && pat_idx == 0, "R1", "key and index at reset",
              {result_key, pat_idx}, 0);

        for (int r = 0; r < NROWS; r++) begin
            run(ROWS[r][24:9], ROWS[r][8:1], cyc, nver, fnd, key);
            cyc_tab[r] = cyc;
            // R4 R3 R5: exact key recovered through the confirmed check
            check(fnd == ROWS[r][0], "R5", "found flag", fnd, ROWS[r][0]);
            check(key == TRUE_KEY, "R4", "recovered key (R3 cost)", key, TRUE_KEY);
            // R6: one extra check per false match
            check(nver == int'(ROWS[r][8:1]) + 1, "R6", "check requests", nver,
                  int'(ROWS[r][8:1]) + 1);
            if (ROWS[r][8:1] == 0) begin
                // R10: one pass suffices
                check(cyc <= 170, "R10", "single pass length", cyc, 170);
            end
        end

        // R9: zero seed behaves as seed 1
        check(cyc_tab[1] == cyc_tab[2], "R9", "seed zero equals seed one",
              cyc_tab[2], cyc_tab[1]);
        // R9: repeatability
        run(16'hACE1, 8'd0, cyc, nver, fnd, key);
        check(cyc == cyc_tab[0] && key == TRUE_KEY, "R9", "repeat run", cyc, cyc_tab[0]);

        // R7: oracle never accepts, budget runs out
        run(16'h1357, 8'd255, cyc, nver, fnd, key);
        check(fnd == 1'b0, "R7", "budget exhausted gives no key", fnd, 0);
        check(nver >= 1, "R7", "false matches seen before giving up", nver, 1);

        // R2
        check(pat_bad == 0 && pat_seen > 0, "R2", "pattern bus matches table", pat_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule